// File: doc/BRIEF.md
# Display Power Sequencer

This block turns a display pipeline on and off in a fixed order. It drives one enable line to each unit of the pipeline: the pixel-clock PLL, the timing pipe, a set of planes (bit 0 is the primary surface, the higher bits are cursor or overlay planes), a set of output connectors, and the legacy text-mode emulation. It does not contain those units. It only decides when each one may switch.

A power-down command turns the units off in this order: connectors, then planes, then the pipe, then the PLL, and last the legacy emulation. Each step takes one clock. A power-up command turns the PLL on and holds a settling wait, set in microseconds and converted to cycles from the clock frequency. It then enables the pipe and loads the active-size registers. After that it checks the surface stride: if the stride is legal the masked planes are enabled, otherwise the sequence stops with an error. The masked connectors come on last. The enables obey interlocks: a downstream unit is on only while its upstream unit is on.

The block shows its progress on three flags: busy, done and error. A command that arrives while a sequence is running is dropped and sets the error flag.

Top module: `disp_pwr_seq`

## Requirements
- R1: After reset, pll_en, pipe_en, plane_en, conn_en, busy, done, err, src_h, src_v and surf_stride are all zero, and vga_emul_en is one.
- R2: In idle, a cmd_down pulse seen at a clock edge produces these changes, one per following edge. Edge 1 clears conn_en. Edge 2 clears plane_en. Edge 3 clears pipe_en. Edge 4 clears pll_en. Edge 5 clears vga_emul_en, sets done and drops busy. No other enable changes at these edges.
- R3: In idle, a cmd_up pulse with a legal stride produces these changes. pll_en rises at edge 1. pipe_en rises SETTLE_CYC+1 edges later. plane_en takes the latched plane mask one edge after that. conn_en takes the latched connector mask one edge later, at which point done rises and busy falls.
- R4: SETTLE_CYC = CLK_KHZ*SETTLE_US/1000. pipe_en is still low SETTLE_CYC edges after pll_en rises and goes high at the next edge.
- R5: pipe_en is never high while pll_en is low. No plane_en bit is high while pipe_en is low.
- R6: conn_en changes only at edges where pipe_en is high both before and after the edge.
- R7: A stride whose low log2(STRIDE_ALIGN) bits (6 bits by default, a multiple of 64 is legal) are not all zero stops power-up at the plane step. At that edge err rises, busy falls and done stays low. plane_en and conn_en stay zero, while the PLL and pipe stay on.
- R8: plane_mask, conn_mask, stride, hact and vact are captured at the accepted command. surf_stride shows the captured stride from the next edge on. src_h and src_v take the captured hact and vact at the edge where pipe_en rises.
- R9: cmd_up or cmd_down while busy is ignored (the running sequence finishes unchanged) and err is set at the next edge. cmd_up and cmd_down together in idle start nothing and set err.
- R10: An accepted command clears err and done and raises busy at the next edge. busy stays high until the sequence ends. done stays high until the next accepted command.
- R11: vga_emul_en falls only at the last power-down step, while the PLL and pipe are already off. A power-up never sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_up | input | 1 | Power-up command pulse |
| cmd_down | input | 1 | Power-down command pulse |
| plane_mask | input | NPLANE | Planes to enable on power-up (bit 0 primary) |
| conn_mask | input | NCONN | Connectors to enable on power-up |
| stride | input | STRIDE_W | Surface stride in bytes |
| hact | input | SIZE_W | Active width of the mode |
| vact | input | SIZE_W | Active height of the mode |
| pll_en | output | 1 | Pixel-clock PLL enable |
| pipe_en | output | 1 | Timing pipe enable |
| plane_en | output | NPLANE | Plane enables |
| conn_en | output | NCONN | Connector enables |
| vga_emul_en | output | 1 | Legacy text-mode emulation enable |
| src_h | output | SIZE_W | Pipe source width |
| src_v | output | SIZE_W | Pipe source height |
| surf_stride | output | STRIDE_W | Captured surface stride |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence completed |
| err | output | 1 | Rejected command or illegal stride |

## Verification
A wrong state in the sequencer shows up at the ports as an enable that switches at the wrong edge, or as two enables that switch at the same edge. Each step moves exactly one enable one edge after the step before it, so a skipped or repeated state is visible within one clock. A miscounted settling timer shifts the rise of pipe_en relative to pll_en by the size of the error. A lost capture of the masks or the stride appears as wrong plane, connector or stride values on the edge that applies them.

// File: rtl/dps_pkg.sv
`timescale 1ns/1ps
package dps_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DN_CONN,
      ST_DN_PLANE,
      ST_DN_PIPE,
      ST_DN_PLL,
      ST_DN_VGA,
      ST_UP_PLL,
      ST_UP_WAIT,
      ST_UP_PIPE,
      ST_UP_PLANE,
      ST_UP_CONN
   } dps_state_e;

   function automatic int unsigned settle_cycles(input int unsigned clk_khz,
                                                 input int unsigned wait_us);
      return (clk_khz * wait_us) / 1000;
   endfunction

endpackage

// File: rtl/dps_settle_timer.sv
`timescale 1ns/1ps
module dps_settle_timer #(
   parameter int unsigned CYCLES = 30000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expired
);
   localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= LOAD_VAL;
      end else if (run && (cnt != '0)) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/dps_stride_chk.sv
`timescale 1ns/1ps
module dps_stride_chk #(
   parameter int unsigned STRIDE_W     = 16,
   parameter int unsigned STRIDE_ALIGN = 64
) (
   input  logic [STRIDE_W-1:0] stride,
   output logic                legal
);
   localparam int unsigned ALIGN_BITS = $clog2(STRIDE_ALIGN);

   generate
      if (ALIGN_BITS == 0) begin : g_any
         logic unused_ok;
         assign unused_ok = ^stride;
         assign legal = 1'b1 | unused_ok;
      end else begin : g_mask
         assign legal = (stride[ALIGN_BITS-1:0] == '0);
      end
   endgenerate

endmodule

// File: rtl/dps_ctrl.sv
`timescale 1ns/1ps
module dps_ctrl
   import dps_pkg::*;
#(
   parameter int unsigned NPLANE   = 3,
   parameter int unsigned NCONN    = 2,
   parameter int unsigned STRIDE_W = 16,
   parameter int unsigned SIZE_W   = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_up,
   input  logic                cmd_down,
   input  logic [NPLANE-1:0]   plane_mask,
   input  logic [NCONN-1:0]    conn_mask,
   input  logic [STRIDE_W-1:0] stride,
   input  logic [SIZE_W-1:0]   hact,
   input  logic [SIZE_W-1:0]   vact,
   input  logic                tmr_expired,
   input  logic                stride_legal,
   output logic                tmr_load,
   output logic                tmr_run,
   output logic [STRIDE_W-1:0] stride_q,
   output logic                pll_en,
   output logic                pipe_en,
   output logic [NPLANE-1:0]   plane_en,
   output logic [NCONN-1:0]    conn_en,
   output logic                vga_emul_en,
   output logic [SIZE_W-1:0]   src_h,
   output logic [SIZE_W-1:0]   src_v,
   output logic                busy,
   output logic                done,
   output logic                err
);
   dps_state_e          state;
   logic [NPLANE-1:0]   pmask_q;
   logic [NCONN-1:0]    cmask_q;
   logic [SIZE_W-1:0]   hact_q;
   logic [SIZE_W-1:0]   vact_q;

   assign busy     = (state != ST_IDLE);
   assign tmr_load = (state == ST_UP_PLL);
   assign tmr_run  = (state == ST_UP_WAIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         pll_en      <= 1'b0;
         pipe_en     <= 1'b0;
         plane_en    <= '0;
         conn_en     <= '0;
         vga_emul_en <= 1'b1;
         src_h       <= '0;
         src_v       <= '0;
         stride_q    <= '0;
         pmask_q     <= '0;
         cmask_q     <= '0;
         hact_q      <= '0;
         vact_q      <= '0;
         done        <= 1'b0;
         err         <= 1'b0;
      end else begin
         if ((state != ST_IDLE) && (cmd_up || cmd_down)) begin
            err <= 1'b1;
         end
         unique case (state)
            ST_IDLE: begin
               if (cmd_up && cmd_down) begin
                  err <= 1'b1;
               end else if (cmd_up) begin
                  pmask_q  <= plane_mask;
                  cmask_q  <= conn_mask;
                  stride_q <= stride;
                  hact_q   <= hact;
                  vact_q   <= vact;
                  err      <= 1'b0;
                  done     <= 1'b0;
                  state    <= ST_UP_PLL;
               end else if (cmd_down) begin
                  err   <= 1'b0;
                  done  <= 1'b0;
                  state <= ST_DN_CONN;
               end
            end
            ST_DN_CONN: begin
               if (pipe_en) conn_en <= '0;
               state <= ST_DN_PLANE;
            end
            ST_DN_PLANE: begin
               plane_en <= '0;
               state    <= ST_DN_PIPE;
            end
            ST_DN_PIPE: begin
               pipe_en <= 1'b0;
               state   <= ST_DN_PLL;
            end
            ST_DN_PLL: begin
               pll_en <= 1'b0;
               state  <= ST_DN_VGA;
            end
            ST_DN_VGA: begin
               vga_emul_en <= 1'b0;
               done        <= 1'b1;
               state       <= ST_IDLE;
            end
            ST_UP_PLL: begin
               pll_en <= 1'b1;
               state  <= ST_UP_WAIT;
            end
            ST_UP_WAIT: begin
               if (tmr_expired) state <= ST_UP_PIPE;
            end
            ST_UP_PIPE: begin
               pipe_en <= pll_en;
               src_h   <= hact_q;
               src_v   <= vact_q;
               state   <= ST_UP_PLANE;
            end
            ST_UP_PLANE: begin
               if (!stride_legal || !pipe_en) begin
                  err   <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  plane_en <= pmask_q;
                  state    <= ST_UP_CONN;
               end
            end
            ST_UP_CONN: begin
               if (pipe_en) conn_en <= cmask_q;
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/disp_pwr_seq.sv
`timescale 1ns/1ps
module disp_pwr_seq
   import dps_pkg::*;
#(
   parameter int unsigned NPLANE       = 3,
   parameter int unsigned NCONN        = 2,
   parameter int unsigned STRIDE_W     = 16,
   parameter int unsigned SIZE_W       = 12,
   parameter int unsigned STRIDE_ALIGN = 64,
   parameter int unsigned CLK_KHZ      = 200000,
   parameter int unsigned SETTLE_US    = 150
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_up,
   input  logic                cmd_down,
   input  logic [NPLANE-1:0]   plane_mask,
   input  logic [NCONN-1:0]    conn_mask,
   input  logic [STRIDE_W-1:0] stride,
   input  logic [SIZE_W-1:0]   hact,
   input  logic [SIZE_W-1:0]   vact,
   output logic                pll_en,
   output logic                pipe_en,
   output logic [NPLANE-1:0]   plane_en,
   output logic [NCONN-1:0]    conn_en,
   output logic                vga_emul_en,
   output logic [SIZE_W-1:0]   src_h,
   output logic [SIZE_W-1:0]   src_v,
   output logic [STRIDE_W-1:0] surf_stride,
   output logic                busy,
   output logic                done,
   output logic                err
);
   localparam int unsigned SETTLE_CYC = settle_cycles(CLK_KHZ, SETTLE_US);
   localparam int unsigned ALIGN_BITS = $clog2(STRIDE_ALIGN);

   generate
      if (NPLANE < 1) begin : g_bad_nplane
         $error("NPLANE must be at least 1");
      end
      if (NCONN < 1) begin : g_bad_nconn
         $error("NCONN must be at least 1");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("settling wait rounds to zero cycles");
      end
      if ((STRIDE_ALIGN == 0) || ((STRIDE_ALIGN & (STRIDE_ALIGN - 1)) != 0)) begin : g_bad_align
         $error("STRIDE_ALIGN must be a power of two");
      end
      if (ALIGN_BITS >= STRIDE_W) begin : g_bad_sw
         $error("STRIDE_W too narrow for STRIDE_ALIGN");
      end
   endgenerate

   logic tmr_load;
   logic tmr_run;
   logic tmr_expired;
   logic stride_legal;

   dps_settle_timer #(
      .CYCLES (SETTLE_CYC)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .run     (tmr_run),
      .expired (tmr_expired)
   );

   dps_stride_chk #(
      .STRIDE_W     (STRIDE_W),
      .STRIDE_ALIGN (STRIDE_ALIGN)
   ) u_stride (
      .stride (surf_stride),
      .legal  (stride_legal)
   );

   dps_ctrl #(
      .NPLANE   (NPLANE),
      .NCONN    (NCONN),
      .STRIDE_W (STRIDE_W),
      .SIZE_W   (SIZE_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_up       (cmd_up),
      .cmd_down     (cmd_down),
      .plane_mask   (plane_mask),
      .conn_mask    (conn_mask),
      .stride       (stride),
      .hact         (hact),
      .vact         (vact),
      .tmr_expired  (tmr_expired),
      .stride_legal (stride_legal),
      .tmr_load     (tmr_load),
      .tmr_run      (tmr_run),
      .stride_q     (surf_stride),
      .pll_en       (pll_en),
      .pipe_en      (pipe_en),
      .plane_en     (plane_en),
      .conn_en      (conn_en),
      .vga_emul_en  (vga_emul_en),
      .src_h        (src_h),
      .src_v        (src_v),
      .busy         (busy),
      .done         (done),
      .err          (err)
   );

endmodule

// File: rtl/dps_checker.sv
`timescale 1ns/1ps
module dps_checker #(
   parameter int unsigned NPLANE       = 3,
   parameter int unsigned NCONN        = 2,
   parameter int unsigned STRIDE_W     = 16,
   parameter int unsigned STRIDE_ALIGN = 64,
   parameter int unsigned SETTLE_CYC   = 30000
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cmd_up,
   input logic                cmd_down,
   input logic                pll_en,
   input logic                pipe_en,
   input logic [NPLANE-1:0]   plane_en,
   input logic [NCONN-1:0]    conn_en,
   input logic                vga_emul_en,
   input logic [STRIDE_W-1:0] surf_stride,
   input logic                busy,
   input logic                done,
   input logic                err
);
   logic [31:0] pll_on_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pll_on_cnt <= '0;
      end else if (!pll_en) begin
         pll_on_cnt <= '0;
      end else if (pll_on_cnt != 32'hFFFF_FFFF) begin
         pll_on_cnt <= pll_on_cnt + 1'b1;
      end
   end

   assert_pipe_needs_pll_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pipe_en |-> pll_en);

   assert_plane_needs_pipe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (plane_en != '0) |-> pipe_en);

   assert_conn_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (conn_en != $past(conn_en)) |-> (pipe_en && $past(pipe_en)));

   assert_pll_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pipe_en) |-> (pll_on_cnt >= 32'(SETTLE_CYC)));

   assert_stride_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((plane_en != '0) && ($past(plane_en) == '0)) |->
         ((32'(surf_stride) % STRIDE_ALIGN) == 0));

   assert_vga_off_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vga_emul_en) |-> (!pll_en && !pipe_en));

   assert_busy_cmd_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (cmd_up || cmd_down)) |=> err);

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

bind disp_pwr_seq dps_checker #(
   .NPLANE       (NPLANE),
   .NCONN        (NCONN),
   .STRIDE_W     (STRIDE_W),
   .STRIDE_ALIGN (STRIDE_ALIGN),
   .SETTLE_CYC   (SETTLE_CYC)
) u_dps_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_up      (cmd_up),
   .cmd_down    (cmd_down),
   .pll_en      (pll_en),
   .pipe_en     (pipe_en),
   .plane_en    (plane_en),
   .conn_en     (conn_en),
   .vga_emul_en (vga_emul_en),
   .surf_stride (surf_stride),
   .busy        (busy),
   .done        (done),
   .err         (err)
);

// File: tb/tb_disp_pwr_seq.sv
`timescale 1ns/1ps
module tb_disp_pwr_seq;
   localparam int unsigned NPL = 3;
   localparam int unsigned NCN = 2;
   localparam int unsigned SW  = 16;
   localparam int unsigned ZW  = 12;
   localparam int unsigned CLK_KHZ = 200000;
   localparam int unsigned SET_US  = 1;
   localparam int unsigned S = (CLK_KHZ * SET_US) / 1000;

   typedef struct packed {
      logic [NPL-1:0] pm;
      logic [NCN-1:0] cm;
      logic [SW-1:0]  str;
      logic [ZW-1:0]  h;
      logic [ZW-1:0]  v;
   } vec_t;

   localparam vec_t VEC [5] = '{
      '{3'b001, 2'b01, 16'd2560, 12'd640,  12'd480},
      '{3'b111, 2'b11, 16'd7680, 12'd1920, 12'd1080},
      '{3'b011, 2'b10, 16'd1000, 12'd1024, 12'd768},
      '{3'b101, 2'b00, 16'd64,   12'd16,   12'd8},
      '{3'b001, 2'b01, 16'd65,   12'd800,  12'd600}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_up = 1'b0, cmd_down = 1'b0;
   logic [NPL-1:0] plane_mask = '0;
   logic [NCN-1:0] conn_mask = '0;
   logic [SW-1:0]  stride = '0;
   logic [ZW-1:0]  hact = '0, vact = '0;
   logic pll_en, pipe_en, vga_emul_en, busy, done, err;
   logic [NPL-1:0] plane_en;
   logic [NCN-1:0] conn_en;
   logic [ZW-1:0]  src_h, src_v;
   logic [SW-1:0]  surf_stride;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   disp_pwr_seq #(
      .NPLANE(NPL), .NCONN(NCN), .STRIDE_W(SW), .SIZE_W(ZW),
      .STRIDE_ALIGN(64), .CLK_KHZ(CLK_KHZ), .SETTLE_US(SET_US)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cmd_up(cmd_up), .cmd_down(cmd_down),
      .plane_mask(plane_mask), .conn_mask(conn_mask), .stride(stride),
      .hact(hact), .vact(vact), .pll_en(pll_en), .pipe_en(pipe_en),
      .plane_en(plane_en), .conn_en(conn_en), .vga_emul_en(vga_emul_en),
      .src_h(src_h), .src_v(src_v), .surf_stride(surf_stride),
      .busy(busy), .done(done), .err(err)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic pulse(input logic up, input logic dn);
      @(negedge clk);
      cmd_up = up; cmd_down = dn;
      @(negedge clk);
      cmd_up = 1'b0; cmd_down = 1'b0;
   endtask

   task automatic run_down();
      logic [NPL-1:0] p_pl; logic p_pipe, p_pll, p_vga;
      p_pl = plane_en; p_pipe = pipe_en; p_pll = pll_en; p_vga = vga_emul_en;
      pulse(1'b0, 1'b1);
      chk("R10", "busy after down cmd", 64'(busy), 64'd1);
      @(negedge clk);
      chk("R2", "conn off step1", 64'(conn_en), 64'd0);
      chk("R2", "planes held step1", 64'(plane_en), 64'(p_pl));
      chk("R10", "err cleared", 64'(err), 64'd0);
      @(negedge clk);
      chk("R2", "planes off step2", 64'(plane_en), 64'd0);
      chk("R2", "pipe held step2", 64'(pipe_en), 64'(p_pipe));
      @(negedge clk);
      chk("R2", "pipe off step3", 64'(pipe_en), 64'd0);
      chk("R2", "pll held step3", 64'(pll_en), 64'(p_pll));
      @(negedge clk);
      chk("R2", "pll off step4", 64'(pll_en), 64'd0);
      chk("R11", "vga held step4", 64'(vga_emul_en), 64'(p_vga));
      @(negedge clk);
      chk("R11", "vga off step5", 64'(vga_emul_en), 64'd0);
      chk("R2", "done/busy end", {62'd0, done, busy}, 64'b10);
   endtask

   task automatic run_up(input vec_t v);
      logic bad;
      bad = (v.str % 64) != 0;
      plane_mask = v.pm; conn_mask = v.cm; stride = v.str; hact = v.h; vact = v.v;
      pulse(1'b1, 1'b0);
      chk("R10", "busy/done after up cmd", {62'd0, busy, done}, 64'b10);
      plane_mask = '0; conn_mask = '0; stride = 16'hFFFF; hact = '0; vact = '0;
      @(negedge clk);
      chk("R3", "pll on step1", {62'd0, pll_en, pipe_en}, 64'b10);
      chk("R8", "stride captured", 64'(surf_stride), 64'(v.str));
      repeat (S) @(negedge clk);
      chk("R4", "pipe still off at settle end", 64'(pipe_en), 64'd0);
      @(negedge clk);
      chk("R4", "pipe on after settle", 64'(pipe_en), 64'd1);
      chk("R8", "src_h", 64'(src_h), 64'(v.h));
      chk("R8", "src_v", 64'(src_v), 64'(v.v));
      chk("R3", "planes off at pipe step", 64'(plane_en), 64'd0);
      @(negedge clk);
      if (bad) begin
         chk("R7", "err/busy/done on bad stride", {61'd0, err, busy, done}, 64'b100);
         chk("R7", "planes stay off", 64'(plane_en), 64'd0);
         @(negedge clk);
         chk("R7", "conns stay off", 64'(conn_en), 64'd0);
         chk("R7", "pll/pipe stay on", {62'd0, pll_en, pipe_en}, 64'b11);
      end else begin
         chk("R3", "planes masked", 64'(plane_en), 64'(v.pm));
         chk("R3", "conns still off", 64'(conn_en), 64'd0);
         @(negedge clk);
         chk("R3", "conns masked", 64'(conn_en), 64'(v.cm));
         chk("R10", "done/busy/err end", {61'd0, done, busy, err}, 64'b100);
      end
      chk("R11", "vga stays off after up", 64'(vga_emul_en), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "enables", {59'd0, pll_en, pipe_en, plane_en != '0, conn_en != '0, vga_emul_en}, 64'b00001);
      chk("R1", "flags", {61'd0, busy, done, err}, 64'd0);
      chk("R1", "src/stride", {src_h, src_v, surf_stride}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      run_down();
      foreach (VEC[i]) begin
         run_up(VEC[i]);
         run_down();
      end

      // R9: both commands together in idle
      pulse(1'b1, 1'b1);
      chk("R9", "both cmds err", {62'd0, err, busy}, 64'b10);
      chk("R9", "both cmds no pll", 64'(pll_en), 64'd0);

      // R9: command during a running sequence
      plane_mask = 3'b010; conn_mask = 2'b10; stride = 16'd128; hact = 12'd320; vact = 12'd200;
      pulse(1'b1, 1'b0);
      chk("R10", "accepted cmd clears err", 64'(err), 64'd0);
      repeat (4) @(negedge clk);
      cmd_down = 1'b1;
      @(negedge clk);
      cmd_down = 1'b0;
      chk("R9", "err on busy cmd", 64'(err), 64'd1);
      chk("R9", "pll kept on", 64'(pll_en), 64'd1);
      repeat (S + 2) @(negedge clk);
      chk("R9", "sequence finished unchanged", {59'd0, conn_en, plane_en}, {59'd0, 2'b10, 3'b010});
      chk("R9", "err held, done set", {62'd0, err, done}, 64'b11);
      run_down();

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule